// File: doc/BRIEF.md
# Multi-Source Event Timestamp FIFO

This block timestamps edges arriving on up to sixteen external event lanes. Each usable lane has an enable bit and, except for the top lane, a prescaler. A lane produces an event on a selected rising edge. In every cycle where at least one lane produces an event, one record is queued. The record holds a bitmap of the lanes that fired in that cycle and the 32-bit nanosecond time presented on `timeNs` at that clock edge. Edges that arrive together therefore share a single record.

Records wait in a sixteen-deep hardware queue. Software reads them over a simple single-cycle register port. Each record comes out as two words: the bitmap first, then the time. A status word reports whether the queue is empty, whether a record was lost or a read came up empty, and how full the queue is in quarters. Writing zero to the status word empties the queue and clears both error flags. The time base and the input synchronisers sit outside this block.

Top module: `evt_stamp_fifo`

## Requirements
- R1: After reset the queue is empty, both error flags and the level field are zero, all enable bits read zero and all prescaler fields read zero.
- R2: A rising edge on an enabled lane whose prescaler is 0 queues one record. The first data read returns the lane bitmap in bits 15:0, with bit i standing for lane i. The second data read returns the `timeNs` value sampled at the clock edge where the input is first seen high.
- R3: Enabled lanes that rise at the same clock edge produce one record whose bitmap has every one of those lanes set.
- R4: A prescaler value N on lanes 4 to 14 records only every (N+1)th rising edge of that lane. The edge count restarts while the lane is disabled.
- R5: Lane 15 has no prescaler and records every rising edge while enabled.
- R6: Lanes 0 to 3 never appear in a record. Their enable bits always read back as zero.
- R7: Edges on disabled lanes queue nothing.
- R8: The queue holds 16 records and returns them in arrival order.
- R9: A record arriving while 16 are already stored is dropped whole. Overflow (status bit 3) is set and the stored records are unchanged.
- R10: A data read while the queue is empty returns zero and sets underflow (status bit 2).
- R11: A write of zero to the status word empties the queue and clears overflow and underflow. A nonzero write to the status word changes nothing.
- R12: Status bit 4 is set exactly when the queue is empty. Status bits 10:8 hold the number of complete quarters of the queue that are filled (0 to 4).
- R13: Register word addresses are 0 for data (a read pops), 1 for status, 2 for lane enables in bits 15:0, and 3 to 8 for prescalers. Address 3+k holds lane 4+2k in bits 15:0 and lane 5+2k in bits 31:16. Lane 15's half of address 8 reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| timeNs | input | 32 | Current time in nanoseconds from the external time base |
| srcIn | input | 16 | Synchronised event lane levels |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Register read strobe (pops on data address) |
| busAddr | input | 4 | Register word address |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data, valid in the cycle of the read |

## Verification
On every cycle, the embedded properties check that occupancy never exceeds sixteen and that a record arriving at a full queue leaves the write pointer where it was and raises overflow. They also check that an empty read raises underflow, that a status clear empties the queue and clears both flags, that the level field stays within range, and that an edge on the top lane always queues. Only the bench's scenarios can show that the bitmap and time words come back in arrival order with the right contents. The same holds for prescaler counting across enable changes, for coincident edges merging into one record, and for the register map readback. These are checked against a reference queue model under directed cases and seeded random traffic.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;

  localparam int ADDR_W = 4;
  localparam int BUS_W  = 32;
  localparam int HALF_W = 16;

  localparam logic [ADDR_W-1:0] ADDR_DATA = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_EN   = 4'd2;
  localparam int                ADDR_DIV0 = 3;

  localparam int ST_UNDER = 2;
  localparam int ST_OVER  = 3;
  localparam int ST_EMPTY = 4;
  localparam int ST_LVL   = 8;
  localparam int LVL_W    = 3;

  typedef struct packed {
    logic push;
    logic popWord;
    logic clear;
  } dpStrobe_t;

endpackage

// File: rtl/evt_stamp_ctrl.sv
module evt_stamp_ctrl
  import evt_stamp_pkg::*;
#(
  parameter int LANES      = 16,
  parameter int FIRST_LANE = 4,
  parameter int NODIV_LANE = 15,
  parameter int DIV_W      = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [LANES-1:0]       srcIn,
  input  logic                   busWe,
  input  logic                   busRe,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [BUS_W-1:0]       busWdata,
  output logic [BUS_W-1:0]       cfgRdata,
  output logic [LANES-1:0]       fireVec,
  output dpStrobe_t              strb
);

  localparam int NDIV = LANES - FIRST_LANE;
  localparam logic [LANES-1:0] VALID_MASK = ~LANES'((1 << FIRST_LANE) - 1);

  logic [LANES-1:0]            prevSrc;
  logic [LANES-1:0]            riseVec;
  logic [LANES-1:0]            srcEn;
  logic [NDIV-1:0][DIV_W-1:0]  divOut;

  always_ff @(posedge clk) begin
    if (!rstN) prevSrc <= '0;
    else       prevSrc <= srcIn;
  end

  assign riseVec = srcIn & ~prevSrc;

  always_ff @(posedge clk) begin
    if (!rstN)
      srcEn <= '0;
    else if (busWe && busAddr == ADDR_EN)
      srcEn <= busWdata[LANES-1:0] & VALID_MASK;
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    if (g < FIRST_LANE) begin : gUnused
      assign fireVec[g] = riseVec[g] & srcEn[g];
    end else if (g == NODIV_LANE) begin : gDirect
      assign fireVec[g]            = riseVec[g] & srcEn[g];
      assign divOut[g-FIRST_LANE]  = '0;
    end else begin : gPrescale
      localparam int SLOT    = g - FIRST_LANE;
      localparam int REG_IDX = ADDR_DIV0 + SLOT / 2;
      localparam int LSB     = (SLOT % 2) * HALF_W;
      logic [DIV_W-1:0] divReg;
      logic [DIV_W-1:0] edgeCnt;
      logic             hitNow;

      assign hitNow = edgeCnt >= divReg;

      always_ff @(posedge clk) begin
        if (!rstN)
          divReg <= '0;
        else if (busWe && busAddr == ADDR_W'(REG_IDX))
          divReg <= busWdata[LSB +: DIV_W];
      end

      always_ff @(posedge clk) begin
        if (!rstN || !srcEn[g])
          edgeCnt <= '0;
        else if (riseVec[g])
          edgeCnt <= hitNow ? '0 : edgeCnt + 1'b1;
      end

      assign fireVec[g]           = riseVec[g] & srcEn[g] & hitNow;
      assign divOut[SLOT]         = divReg;
    end
  end

  always_comb begin
    cfgRdata = '0;
    if (busAddr == ADDR_EN)
      cfgRdata[LANES-1:0] = srcEn;
    for (int l = 0; l < NDIV; l++) begin
      if (int'(busAddr) == ADDR_DIV0 + l / 2)
        cfgRdata[(l % 2) * HALF_W +: DIV_W] = divOut[l];
    end
  end

  assign strb.push    = |fireVec;
  assign strb.popWord = busRe && busAddr == ADDR_DATA;
  assign strb.clear   = busWe && busAddr == ADDR_STAT && busWdata == '0;

  AST_NODIV_EVERY: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(srcIn[NODIV_LANE]) && srcEn[NODIV_LANE]) |-> strb.push); // R5

  AST_LOW_EN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $past(busWe && busAddr == ADDR_EN) |-> srcEn[FIRST_LANE-1:0] == '0); // R6

endmodule

// File: rtl/evt_stamp_dp.sv
module evt_stamp_dp
  import evt_stamp_pkg::*;
#(
  parameter int MAP_W = 16,
  parameter int TS_W  = 32,
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [MAP_W-1:0]  fireVec,
  input  logic [TS_W-1:0]   timeNs,
  output logic [BUS_W-1:0]  dataWord,
  output logic [BUS_W-1:0]  statusWord
);

  localparam int PTR_W   = $clog2(DEPTH);
  localparam int CNT_W   = PTR_W + 1;
  localparam int QUARTER = DEPTH / 4;

  logic [MAP_W-1:0] mapMem [DEPTH];
  logic [TS_W-1:0]  tsMem  [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             halfSel;
  logic             ovfFlag, undFlag;
  logic             isEmpty, isFull, doPush, doPop;
  logic [LVL_W-1:0] level;

  assign isEmpty = count == '0;
  assign isFull  = count == CNT_W'(DEPTH);
  assign doPush  = strb.push && !isFull && !strb.clear;
  assign doPop   = strb.popWord && !isEmpty && halfSel && !strb.clear;

  always_ff @(posedge clk) begin
    if (doPush) begin
      mapMem[wrPtr] <= fireVec;
      tsMem[wrPtr]  <= timeNs;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      halfSel <= 1'b0;
      ovfFlag <= 1'b0;
      undFlag <= 1'b0;
    end else begin
      if (doPush)
        wrPtr <= wrPtr + 1'b1;
      if (strb.push && isFull)
        ovfFlag <= 1'b1;
      if (strb.popWord) begin
        if (isEmpty)
          undFlag <= 1'b1;
        else if (halfSel) begin
          rdPtr   <= rdPtr + 1'b1;
          halfSel <= 1'b0;
        end else
          halfSel <= 1'b1;
      end
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  always_comb begin
    dataWord = '0;
    if (!isEmpty) begin
      if (halfSel) dataWord[TS_W-1:0]  = tsMem[rdPtr];
      else         dataWord[MAP_W-1:0] = mapMem[rdPtr];
    end
  end

  assign level = LVL_W'(count / CNT_W'(QUARTER));

  always_comb begin
    statusWord                       = '0;
    statusWord[ST_UNDER]             = undFlag;
    statusWord[ST_OVER]              = ovfFlag;
    statusWord[ST_EMPTY]             = isEmpty;
    statusWord[ST_LVL +: LVL_W]      = level;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)); // R8

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && isFull && !strb.popWord && !strb.clear)
      |=> (statusWord[ST_OVER] && isFull && wrPtr == $past(wrPtr))); // R9

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rstN)
    (strb.popWord && isEmpty && !strb.clear) |=> statusWord[ST_UNDER]); // R10

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (statusWord[ST_EMPTY] && !statusWord[ST_OVER] && !statusWord[ST_UNDER])); // R11

  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[ST_LVL +: LVL_W] <= LVL_W'(4)); // R12

endmodule

// File: rtl/evt_stamp_fifo.sv
module evt_stamp_fifo
  import evt_stamp_pkg::*;
#(
  parameter int LANES      = 16,
  parameter int FIRST_LANE = 4,
  parameter int NODIV_LANE = 15,
  parameter int DIV_W      = 16,
  parameter int TS_W       = 32,
  parameter int DEPTH      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TS_W-1:0]   timeNs,
  input  logic [LANES-1:0]  srcIn,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [3:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata
);

  dpStrobe_t         strb;
  logic [LANES-1:0]  fireVec;
  logic [BUS_W-1:0]  cfgRdata, dataWord, statusWord;

  evt_stamp_ctrl #(
    .LANES(LANES), .FIRST_LANE(FIRST_LANE), .NODIV_LANE(NODIV_LANE), .DIV_W(DIV_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .srcIn(srcIn),
    .busWe(busWe), .busRe(busRe), .busAddr(busAddr), .busWdata(busWdata),
    .cfgRdata(cfgRdata), .fireVec(fireVec), .strb(strb)
  );

  evt_stamp_dp #(
    .MAP_W(LANES), .TS_W(TS_W), .DEPTH(DEPTH)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fireVec(fireVec), .timeNs(timeNs),
    .dataWord(dataWord), .statusWord(statusWord)
  );

  always_comb begin
    case (busAddr)
      ADDR_DATA: busRdata = dataWord;
      ADDR_STAT: busRdata = statusWord;
      default:   busRdata = cfgRdata;
    endcase
  end

endmodule

// File: tb/test_evt_stamp_fifo.sv
module test_evt_stamp_fifo;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] timeNs = '0;
  logic [15:0] srcIn = '0;
  logic        busWe = 1'b0, busRe = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;

  evt_stamp_fifo i_evt_stamp_fifo (
    .clk(clk), .rstN(rstN), .timeNs(timeNs), .srcIn(srcIn),
    .busWe(busWe), .busRe(busRe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  logic [15:0] mEn = '0;
  int          mDiv [16];
  int          mCnt [16];
  logic [15:0] qMap [$];
  logic [31:0] qTs  [$];
  bit          mHalf = 0, mOvf = 0, mUnd = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] mdlStatus();
    logic [31:0] s = '0;
    s[10:8] = 3'(qMap.size() / 4);
    s[4] = (qMap.size() == 0);
    s[3] = mOvf;
    s[2] = mUnd;
    return s;
  endfunction

  function automatic logic [31:0] mdlRead();
    logic [31:0] r = '0;
    if (qMap.size() == 0) mUnd = 1;
    else if (!mHalf) begin r[15:0] = qMap[0]; mHalf = 1; end
    else begin r = qTs[0]; void'(qMap.pop_front()); void'(qTs.pop_front()); mHalf = 0; end
    return r;
  endfunction

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); busWe = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1 busWe = 0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); busRe = 1; busAddr = a; #1 d = busRdata;
    @(posedge clk); #1 busRe = 0;
  endtask

  task automatic readData(input string tag);
    logic [31:0] got, exp;
    busRead(4'd0, got); exp = mdlRead(); chk(tag, got, exp);
  endtask

  task automatic readStat(input string tag);
    logic [31:0] got;
    busRead(4'd1, got); chk(tag, got, mdlStatus());
  endtask

  task automatic setEn(input logic [31:0] d);
    busWrite(4'd2, d);
    for (int l = 0; l < 16; l++) if (!d[l]) mCnt[l] = 0;
    mEn = d[15:0] & 16'hFFF0;
  endtask

  task automatic setDiv(input int a, input logic [31:0] d);
    int lo;
    busWrite(4'(a), d);
    lo = 4 + 2 * (a - 3);
    mDiv[lo] = int'(d[15:0]);
    if (lo + 1 < 15) mDiv[lo+1] = int'(d[31:16]);
  endtask

  task automatic clearQ();
    busWrite(4'd1, 32'd0);
    qMap.delete(); qTs.delete(); mHalf = 0; mOvf = 0; mUnd = 0;
  endtask

  task automatic pulse(input logic [15:0] mask, input logic [31:0] ts);
    logic [15:0] fire = '0;
    @(negedge clk); timeNs = ts; srcIn = mask;
    @(posedge clk); #1;
    @(negedge clk); srcIn = '0;
    for (int l = 4; l < 16; l++) begin
      if (!mEn[l]) mCnt[l] = 0;
      else if (mask[l]) begin
        if (l == 15) fire[l] = 1;
        else if (mCnt[l] >= mDiv[l]) begin fire[l] = 1; mCnt[l] = 0; end
        else mCnt[l]++;
      end
    end
    if (fire != 0) begin
      if (qMap.size() < 16) begin qMap.push_back(fire); qTs.push_back(ts); end
      else mOvf = 1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    for (int l = 0; l < 16; l++) begin mDiv[l] = 0; mCnt[l] = 0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1 / R12 reset state
    busRead(4'd1, v); chk("R1 status", v, 32'h10);
    busRead(4'd2, v); chk("R1 enable", v, 0);
    busRead(4'd5, v); chk("R1 prescaler", v, 0);

    // R6 low enable bits always zero
    setEn(32'hFFFF);
    busRead(4'd2, v); chk("R6 enable readback", v, 32'hFFF0);

    // R13 prescaler map
    busWrite(4'd3, 32'h0007_0005); busRead(4'd3, v); chk("R13 addr3", v, 32'h0007_0005);
    busWrite(4'd8, 32'hABCD_0009); busRead(4'd8, v); chk("R13 addr8 lane15 half", v, 32'h0000_0009);
    busWrite(4'd3, 0); busWrite(4'd8, 0);

    // R2 single event
    setEn(32'h0010);
    pulse(16'h0010, 32'h1234_5678);
    readStat("R12 one entry");
    busRead(4'd0, v); void'(mdlRead()); chk("R2 bitmap", v, 32'h10);
    busRead(4'd0, v); void'(mdlRead()); chk("R2 time", v, 32'h1234_5678);

    // R3 coincident edges
    setEn(32'h00F0);
    pulse(16'h00F0, 32'hCAFE_0001);
    busRead(4'd0, v); void'(mdlRead()); chk("R3 merged bitmap", v, 32'hF0);
    readData("R3 time");

    // R6 / R7 ignored lanes
    pulse(16'h000F, 32'h1);
    pulse(16'h0100, 32'h2);
    busRead(4'd1, v); chk("R7 nothing queued", v, 32'h10);

    // R4 prescaler on lane 6 = 2
    setEn(32'h0040);
    setDiv(4, 32'h0000_0002);
    pulse(16'h0040, 32'd10);
    pulse(16'h0040, 32'd20);
    busRead(4'd1, v); chk("R4 no record yet", v, 32'h10);
    for (int i = 3; i <= 6; i++) pulse(16'h0040, 32'(i * 10));
    busRead(4'd0, v); void'(mdlRead()); chk("R4 bitmap", v, 32'h40);
    busRead(4'd0, v); void'(mdlRead()); chk("R4 third edge time", v, 32'd30);
    readData("R4 bitmap 2");
    busRead(4'd0, v); void'(mdlRead()); chk("R4 sixth edge time", v, 32'd60);

    // R5 lane 15 every edge
    setEn(32'h8000);
    for (int i = 0; i < 3; i++) pulse(16'h8000, 32'(500 + i));
    busRead(4'd1, v); chk("R5 three records", v, 32'h0);
    for (int i = 0; i < 6; i++) readData("R5 contents");

    // R8 / R9 fill and overflow
    for (int i = 0; i < 16; i++) pulse(16'h8000, 32'(100 + i));
    readStat("R8 full level");
    pulse(16'h8000, 32'd999);
    busRead(4'd1, v); chk("R9 overflow flag", v, 32'h0408);
    for (int i = 0; i < 32; i++) readData("R8 order");

    // R10 empty read
    busRead(4'd0, v); void'(mdlRead()); chk("R10 empty data", v, 0);
    busRead(4'd1, v); chk("R10 underflow flag", v, 32'h1C);

    // R11 clear
    pulse(16'h8000, 32'd7);
    busWrite(4'd1, 32'h5);
    readStat("R11 nonzero write ignored");
    clearQ();
    busRead(4'd1, v); chk("R11 cleared", v, 32'h10);

    // Random traffic
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom % 10);
      if (op < 4) pulse(16'($urandom), $urandom);
      else if (op < 7) readData("R2 random data");
      else if (op == 7) readStat("R12 random status");
      else if (op == 8) setEn($urandom);
      else setDiv(3 + int'($urandom % 6), {14'd0, 2'($urandom), 14'd0, 2'($urandom)});
    end
    while (qMap.size() != 0) readData("R8 drain");
    readStat("R12 final");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule